// File: doc/BRIEF.md
# Maskable Interrupt Vector Manager

This block collects a set of interrupt sources (external device lines and internal timer events, all delivered as single-cycle pulses) into one pending vector. A software mask picks which pending bits may reach the processor, and one output line is driven whenever any unmasked bit is pending. Software drives a simple operation port with a code and a data word. It can raise bits, acknowledge bits with a check that they really were pending, clear bits quietly, load the mask, and clear bits of a sticky error log.

The raw pending vector and the masked vector are both visible on output ports at all times. An eight-bit error log keeps a record of protocol problems. These are: acknowledging a bit that was not pending, a new system interrupt arriving before the previous one was taken, and two compare-in-the-past warnings that the timers deliver. Bit 0 of the vector is the system interrupt. The vector width is a parameter of at least 8.

Top module: `irq_vector_mgr`

## Requirements
- R1: After reset the pending vector, the mask and the error log are all zero and `irq_o` is low.
- R2: A pulse on `src_pulse_i[k]` makes pending bit k read 1 from the next cycle on. When a source pulse and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R3: With `op_valid_i` high and op code 1 (raise), the data word is ORed into the pending vector.
- R4: Op code 2 (acknowledge) clears every pending bit that is set in the data word. If any data bit was not pending in the cycle of the operation, error bit 6 is set.
- R5: Op code 3 (lower) clears pending bits the same way as acknowledge and never changes any error bit.
- R6: Op code 4 loads the data word into the mask. `masked_o` equals pending AND mask. `pend_o` shows every pending bit, whatever the mask holds.
- R7: `irq_o` is high exactly when at least one pending bit has its mask bit set. It stays high until all such bits are cleared or masked.
- R8: Error bit 7 is set when a pulse arrives on source bit 0 while pending bit 0 is already 1 and that bit is not being cleared in the same cycle.
- R9: Error bits 0 and 1 are set by `sys_late_i` and `part_late_i`. Error bits 2 to 5 always read 0.
- R10: Error bits are sticky. Op code 5 clears the error bits that are set in data bits 7:0. When a bit is set and cleared in the same cycle, the set wins.
- R11: With `op_valid_i` low, or with op code 0, 6 or 7, the mask and the pending vector do not change apart from source pulses, and software causes no error bit to change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse_i | input | VEC_W | Single-cycle interrupt source pulses; bit 0 is the system interrupt |
| sys_late_i | input | 1 | System compare programmed in the past (sets error bit 0) |
| part_late_i | input | 1 | Partition compare programmed in the past (sets error bit 1) |
| op_valid_i | input | 1 | Software operation strobe |
| op_code_i | input | 3 | Operation code: 1 raise, 2 ack, 3 lower, 4 mask load, 5 error clear |
| op_data_i | input | VEC_W | Operation data word |
| pend_o | output | VEC_W | Raw pending vector |
| masked_o | output | VEC_W | Pending vector ANDed with mask |
| irq_o | output | 1 | Merged interrupt to the processor |
| err_o | output | 8 | Sticky error log |

## Verification
Directed sequences separate the two clear operations. Acknowledge and lower are given the same data word for bits that are pending and for bits that are not, so only the error-bit-6 result tells them apart. Same-cycle collisions (a source pulse against an acknowledge of the same bit, a warning against an error clear) show whether set takes priority over clear. A repeated system pulse, once with and once without an acknowledge in the same cycle, tells the overrun case apart from a normal re-arm. Seeded random mixes of all op codes (including the unused ones), sparse source pulses and changing masks then exercise how the mask, the `irq_o` merge and the sticky log interact.

// File: rtl/ivm_pkg.sv
package ivm_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_RAISE  = 3'd1,
        OP_ACK    = 3'd2,
        OP_LOWER  = 3'd3,
        OP_MASK   = 3'd4,
        OP_ERRCLR = 3'd5
    } ivm_op_e;

    localparam int ERR_W         = 8;
    localparam int ERR_SYS_LATE  = 0;
    localparam int ERR_PART_LATE = 1;
    localparam int ERR_ACK_BAD   = 6;
    localparam int ERR_OVERRUN   = 7;

endpackage

// File: rtl/ivm_decode.sv
module ivm_decode
    import ivm_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic             op_valid,
    input  logic [2:0]       op_code,
    input  logic [VEC_W-1:0] op_data,
    input  logic [VEC_W-1:0] pend,
    output logic [VEC_W-1:0] sw_set,
    output logic [VEC_W-1:0] sw_clr,
    output logic             mask_we,
    output logic [ERR_W-1:0] err_clr,
    output logic             ack_bad
);

    ivm_op_e op;
    assign op = ivm_op_e'(op_code);

    always_comb begin
        sw_set  = '0;
        sw_clr  = '0;
        mask_we = 1'b0;
        err_clr = '0;
        ack_bad = 1'b0;
        if (op_valid) begin
            unique case (op)
                OP_RAISE:  sw_set = op_data;
                OP_ACK: begin
                    sw_clr  = op_data;
                    ack_bad = |(op_data & ~pend);
                end
                OP_LOWER:  sw_clr = op_data;
                OP_MASK:   mask_we = 1'b1;
                OP_ERRCLR: err_clr = op_data[ERR_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ivm_pending.sv
module ivm_pending #(
    parameter int VEC_W   = 16,
    parameter int SYS_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] sw_set,
    input  logic [VEC_W-1:0] sw_clr,
    output logic [VEC_W-1:0] pend,
    output logic             overrun
);

    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[b] <= 1'b0;
            else if (src[b] || sw_set[b])
                pend[b] <= 1'b1;
            else if (sw_clr[b])
                pend[b] <= 1'b0;
        end
    end

    assign overrun = src[SYS_BIT] & pend[SYS_BIT] & ~sw_clr[SYS_BIT];

endmodule

// File: rtl/ivm_errlog.sv
module ivm_errlog
    import ivm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_late,
    input  logic             part_late,
    input  logic             ack_bad,
    input  logic             overrun,
    input  logic [ERR_W-1:0] clr,
    output logic [ERR_W-1:0] err
);

    logic [ERR_W-1:0] set_bits;

    always_comb begin
        set_bits                = '0;
        set_bits[ERR_SYS_LATE]  = sys_late;
        set_bits[ERR_PART_LATE] = part_late;
        set_bits[ERR_ACK_BAD]   = ack_bad;
        set_bits[ERR_OVERRUN]   = overrun;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= '0;
        else
            err <= (err & ~clr) | set_bits;
    end

endmodule

// File: rtl/irq_vector_mgr.sv
module irq_vector_mgr
    import ivm_pkg::*;
#(
    parameter int VEC_W   = 16,
    parameter int SYS_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] src_pulse_i,
    input  logic             sys_late_i,
    input  logic             part_late_i,
    input  logic             op_valid_i,
    input  logic [2:0]       op_code_i,
    input  logic [VEC_W-1:0] op_data_i,
    output logic [VEC_W-1:0] pend_o,
    output logic [VEC_W-1:0] masked_o,
    output logic             irq_o,
    output logic [ERR_W-1:0] err_o
);

    logic [VEC_W-1:0] sw_set, sw_clr, mask_q;
    logic             mask_we, ack_bad, overrun;
    logic [ERR_W-1:0] err_clr;

    ivm_decode #(.VEC_W(VEC_W)) u_dec (
        .op_valid (op_valid_i),
        .op_code  (op_code_i),
        .op_data  (op_data_i),
        .pend     (pend_o),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .mask_we  (mask_we),
        .err_clr  (err_clr),
        .ack_bad  (ack_bad)
    );

    ivm_pending #(.VEC_W(VEC_W), .SYS_BIT(SYS_BIT)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src_pulse_i),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .pend    (pend_o),
        .overrun (overrun)
    );

    ivm_errlog u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_late  (sys_late_i),
        .part_late (part_late_i),
        .ack_bad   (ack_bad),
        .overrun   (overrun),
        .clr       (err_clr),
        .err       (err_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= op_data_i;
    end

    assign masked_o = pend_o & mask_q;
    assign irq_o    = |masked_o;

endmodule

// File: rtl/irq_vector_mgr_chk.sv
module irq_vector_mgr_chk
    import ivm_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] src_pulse_i,
    input logic             op_valid_i,
    input logic [2:0]       op_code_i,
    input logic [VEC_W-1:0] pend_o,
    input logic [VEC_W-1:0] masked_o,
    input logic             irq_o,
    input logic [ERR_W-1:0] err_o
);

    // R2
    src_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_pulse_i) |=> ((pend_o & $past(src_pulse_i)) == $past(src_pulse_i)));

    // R5
    lower_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_code_i == OP_LOWER) |=> $stable(err_o[ERR_ACK_BAD]));

    // R7
    irq_tracks_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (masked_o != '0));

    // R8
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i && src_pulse_i[0] && pend_o[0]) |=> err_o[ERR_OVERRUN]);

    // R9
    unused_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o[5:2] == 4'b0);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid_i && op_code_i == OP_ERRCLR) |=> ((err_o & $past(err_o)) == $past(err_o)));

    // R11
    idle_pending_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i && src_pulse_i == '0) |=> $stable(pend_o));

endmodule

bind irq_vector_mgr irq_vector_mgr_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/irq_vector_mgr_bench.sv
module irq_vector_mgr_bench;

    localparam int VEC_W  = 16;
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [VEC_W-1:0] src_pulse_i = '0;
    logic             sys_late_i = 1'b0;
    logic             part_late_i = 1'b0;
    logic             op_valid_i = 1'b0;
    logic [2:0]       op_code_i = '0;
    logic [VEC_W-1:0] op_data_i = '0;
    logic [VEC_W-1:0] pend_o, masked_o;
    logic             irq_o;
    logic [7:0]       err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [VEC_W-1:0] m_pend = '0, m_mask = '0;
    logic [7:0]       m_err = '0;

    always #(CLK_NS/2) clk = ~clk;

    irq_vector_mgr #(.VEC_W(VEC_W)) u_irq_vector_mgr (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VEC_W-1:0] nxt_pend(input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] s,
                                                   input logic v, input logic [2:0] op, input logic [VEC_W-1:0] d);
        logic [VEC_W-1:0] set_v, clr_v;
        set_v = s | ((v && op == 3'd1) ? d : '0);
        clr_v = (v && (op == 3'd2 || op == 3'd3)) ? d : '0;
        return (p & ~clr_v) | set_v;
    endfunction

    function automatic logic [7:0] nxt_err(input logic [7:0] e, input logic [VEC_W-1:0] p, input logic [VEC_W-1:0] s,
                                           input logic sl, input logic pl, input logic v,
                                           input logic [2:0] op, input logic [VEC_W-1:0] d);
        logic [7:0] es, ec;
        logic       clr0;
        clr0 = v && (op == 3'd2 || op == 3'd3) && d[0];
        es = '0;
        es[0] = sl;
        es[1] = pl;
        es[6] = v && op == 3'd2 && |(d & ~p);
        es[7] = s[0] && p[0] && !clr0;
        ec = (v && op == 3'd5) ? d[7:0] : 8'h0;
        return (e & ~ec) | es;
    endfunction

    task automatic step(input logic [VEC_W-1:0] s, input logic sl, input logic pl, input logic v,
                        input logic [2:0] op, input logic [VEC_W-1:0] d, input string tag);
        logic [VEC_W-1:0] np;
        logic [7:0]       ne;
        @(negedge clk);
        src_pulse_i = s; sys_late_i = sl; part_late_i = pl;
        op_valid_i = v; op_code_i = op; op_data_i = d;
        np = nxt_pend(m_pend, s, v, op, d);
        ne = nxt_err(m_err, m_pend, s, sl, pl, v, op, d);
        if (v && op == 3'd4) m_mask = d;
        m_pend = np;
        m_err  = ne;
        @(posedge clk);
        #1;
        src_pulse_i = '0; sys_late_i = 1'b0; part_late_i = 1'b0; op_valid_i = 1'b0;
        chk(pend_o === m_pend, {tag, " pend"}, 32'(pend_o), 32'(m_pend));
        chk(masked_o === (m_pend & m_mask), "R6 masked", 32'(masked_o), 32'(m_pend & m_mask));
        chk(irq_o === |(m_pend & m_mask), "R7 irq", 32'(irq_o), 32'(|(m_pend & m_mask)));
        chk(err_o === m_err, {tag, " err"}, 32'(err_o), 32'(m_err));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(pend_o === '0 && err_o === '0 && irq_o === 1'b0, "R1 reset", 32'(pend_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 raise under zero mask: no irq (R7)
        step('0, 0, 0, 1, 3'd1, 16'h00F0, "R3");
        // R6 mask load, R7 irq rises
        step('0, 0, 0, 1, 3'd4, 16'h0010, "R6");
        // R4 good ack of pending bits: no error
        step('0, 0, 0, 1, 3'd2, 16'h0030, "R4");
        // R4 ack of non-pending bit flags error bit 6
        step('0, 0, 0, 1, 3'd2, 16'h0100, "R4");
        // R10 error clear
        step('0, 0, 0, 1, 3'd5, 16'h00FF, "R10");
        // R5 lower of non-pending bits: no error
        step('0, 0, 0, 1, 3'd3, 16'h0300, "R5");
        // R2 source pulse sets bit 0; R8 second pulse is overrun
        step(16'h0001, 0, 0, 0, 3'd0, '0, "R2");
        step(16'h0001, 0, 0, 0, 3'd0, '0, "R8");
        // R2 pulse wins over same-cycle ack; no overrun
        step('0, 0, 0, 1, 3'd5, 16'h0080, "R10");
        step(16'h0001, 0, 0, 1, 3'd2, 16'h0001, "R2");
        // R9 warnings set bits 0 and 1
        step('0, 1, 1, 0, 3'd0, '0, "R9");
        // R10 set wins over clear on same bit
        step('0, 1, 0, 1, 3'd5, 16'h0003, "R10");
        // R11 unused codes and invalid strobe do nothing
        step('0, 0, 0, 1, 3'd6, 16'hFFFF, "R11");
        step('0, 0, 0, 1, 3'd7, 16'hFFFF, "R11");
        step('0, 0, 0, 0, 3'd1, 16'hFFFF, "R11");
        step('0, 0, 0, 0, 3'd4, 16'h0000, "R11");
        // R7 irq stays while unmasked bit pending, drops on lower
        step('0, 0, 0, 1, 3'd4, 16'h0001, "R7");
        step('0, 0, 0, 1, 3'd3, 16'h0001, "R7");

        for (int i = 0; i < 400; i++) begin
            logic [VEC_W-1:0] s, d;
            s = VEC_W'($urandom) & VEC_W'($urandom) & VEC_W'($urandom);
            d = VEC_W'($urandom);
            step(s, ($urandom % 16) == 0, ($urandom % 16) == 0, $urandom % 2,
                 3'($urandom), d, "R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule